// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns an effective address into a real address by walking a tree of page tables held in memory. The caller supplies the effective address, the base of the root table, the number of index bits the root table takes, and the total size of the address space in bits. At every level the walker forms an entry address from the current table base and a slice of the effective address. It then reads one 64-bit entry over a request/acknowledge memory port. Depending on that entry it either goes down to the next table or stops at a leaf.

A leaf produces the real address, the page-size exponent and the raw leaf entry. A walk that cannot complete ends with a fault code instead. There are two fault cases: an entry whose valid bit is clear, or a tree shape outside the supported set of index sizes per level. Table bases that are not naturally aligned are not rejected; their low bits are cleared before use. Permission checks and caching of translations belong to other blocks.

Entry layout used by the walker: bit 63 is valid and bit 62 marks a leaf. In a non-leaf entry, bits 55:8 hold the next table base and bits 4:0 hold the next index size. In a leaf, bits 55:12 hold the real page number.

Top module: `radix_walker`

## Requirements
- R1: While and after reset, `busy`, `done` and `mem_req` are 0.
- R2: At each level the entry address is the aligned table base plus 8 × ((ea >> (size − nls)) & (2^nls − 1)). Here `size` is the remaining address size and `nls` is the current index size. Every entry address therefore has its low 3 bits at zero.
- R3: Before a table base is used, its low (nls + 3) bits are cleared. This applies to the root base and to every next base taken from an entry.
- R4: The walker checks each level before reading it. The legal combinations are:
  - level 0: size 52 and nls 13;
  - levels 1 and 2: nls 9;
  - level 3: nls 9 or 5.

  Any other combination, and any level above 3, ends the walk with cause 2 (bad configuration), and no read is issued for that level.
- R5: A read entry whose bit 63 is 0 ends the walk with cause 1 (no entry).
- R6: A valid entry with bit 62 clear is a non-leaf entry. Bits 55:8 become the next base and bits 4:0 become the next nls. The remaining size drops by the current nls.
- R7: At a leaf the remaining size first drops by the current nls, giving `s`. Then `real_addr` is (entry bits 55:12 in place, low `s` bits cleared) OR (low `s` bits of `ea`), and `page_shift` = `s`.
- R8: On a successful walk, `leaf_entry` carries the leaf entry exactly as it was read.
- R9: Each walk ends with `done` high for exactly one cycle. On success `cause` is 0 alongside the results. On a fault, `real_addr`, `page_shift` and `leaf_entry` read 0.
- R10: A `start` that arrives while `busy` is high is ignored. The running walk completes with its own inputs.
- R11: `mem_req` is high only while busy. Once raised, it holds with a stable `mem_addr` until `mem_ack`, so only one read is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ea | input | 64 | Effective address to translate |
| root_base | input | 64 | Base address of the root table |
| root_nls | input | 5 | Index size of the root table |
| root_size | input | 6 | Total address-space size in bits |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| cause | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| real_addr | output | 64 | Translated real address |
| page_shift | output | 6 | Page-size exponent |
| leaf_entry | output | 64 | Leaf entry that ended the walk |
| mem_req | output | 1 | Read request |
| mem_addr | output | 64 | Entry address being read |
| mem_ack | input | 1 | Read data is valid this cycle |
| mem_rdata | input | 64 | Entry data read |

## Verification
The bench aims at the following cases:
- **Misaligned bases.** Table bases carry garbage in their low bits. A walker that skipped the alignment mask would read an address nobody wrote and report a spurious no-entry fault.
- **Odd tree shapes.** Walks stop at the root with a 39-bit page and at the fourth level with the short 5-bit index, giving a 16-bit page. A wrong shift or a wrong size decrement here shows up as a wrong `page_shift` or a corrupted low half of `real_addr`.
- **Illegal shapes.** Trees are given a disallowed index size at some level, or run past level 3, or have a bad root. These must fault with no read for that level; a walker with a loose legality check would fetch anyway and return a translation.
- **Start while busy.** A second `start` arrives during a walk. A walker that restarted would report the second walk's result in place of the first.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int VA_W  = 64;
    localparam int ENT_W = 64;
    localparam int SZ_W  = 6;
    localparam int NLS_W = 5;
    localparam int LVL_W = 3;
    localparam int MSK_W = 7;

    // entry field positions (decoded by the walker and by the tables it reads)
    localparam int V_BIT  = 63;
    localparam int L_BIT  = 62;
    localparam int NB_HI  = 55;
    localparam int NB_LO  = 8;
    localparam int RPN_HI = 55;
    localparam int RPN_LO = 12;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_NOENT  = 2'd1,
        CAUSE_BADCFG = 2'd2
    } walk_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_READ  = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic [VA_W-1:0]  base;
        logic [NLS_W-1:0] nls;
        logic [SZ_W-1:0]  size;
        logic [LVL_W-1:0] lvl;
    } walk_ctx_t;

    typedef struct packed {
        walk_cause_e      cause;
        logic [VA_W-1:0]  raddr;
        logic [SZ_W-1:0]  shift;
        logic [ENT_W-1:0] leaf;
    } walk_result_t;

    // ones in bits [n-1:0]
    function automatic logic [VA_W-1:0] low_ones(input logic [MSK_W-1:0] n);
        if (n >= MSK_W'(VA_W)) return '1;
        return (VA_W'(1) << n) - VA_W'(1);
    endfunction

    function automatic logic [VA_W-1:0] field_mask(input int hi, input int lo);
        return low_ones(MSK_W'(hi + 1)) & ~low_ones(MSK_W'(lo));
    endfunction

    function automatic logic [VA_W-1:0] entry_next_base(input logic [ENT_W-1:0] e);
        return e & field_mask(NB_HI, NB_LO);
    endfunction

    function automatic logic [NLS_W-1:0] entry_next_nls(input logic [ENT_W-1:0] e);
        return e[NLS_W-1:0];
    endfunction

endpackage

// File: rtl/radix_walk_index.sv
module radix_walk_index
    import radix_walk_pkg::*;
(
    input  logic [VA_W-1:0]  ea,
    input  logic [VA_W-1:0]  base,
    input  logic [SZ_W-1:0]  size,
    input  logic [NLS_W-1:0] nls,
    output logic [VA_W-1:0]  entry_addr
);
    logic [SZ_W-1:0]  shamt;
    logic [MSK_W-1:0] nls_w;
    logic [MSK_W-1:0] align_w;
    logic [VA_W-1:0]  idx;
    logic [VA_W-1:0]  base_al;

    always_comb begin
        shamt      = size - SZ_W'(nls);
        nls_w      = MSK_W'(nls);
        align_w    = nls_w + MSK_W'(3);
        idx        = (ea >> shamt) & low_ones(nls_w);
        base_al    = base & ~low_ones(align_w);
        entry_addr = base_al + (idx << 3);
    end
endmodule

// File: rtl/radix_walk_cfg.sv
module radix_walk_cfg
    import radix_walk_pkg::*;
#(
    parameter int ROOT_SIZE = 52,
    parameter int ROOT_NLS  = 13,
    parameter int MID_NLS   = 9,
    parameter int ALT_NLS   = 5,
    parameter int DEPTH     = 4
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [SZ_W-1:0]  size,
    input  logic [NLS_W-1:0] nls,
    output logic             legal
);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(DEPTH - 1);
    localparam logic [SZ_W-1:0]  RSIZE    = SZ_W'(ROOT_SIZE);
    localparam logic [NLS_W-1:0] RNLS     = NLS_W'(ROOT_NLS);
    localparam logic [NLS_W-1:0] MNLS     = NLS_W'(MID_NLS);

    logic last_ok;

    generate
        if (ALT_NLS > 0) begin : g_alt
            localparam logic [NLS_W-1:0] ANLS = NLS_W'(ALT_NLS);
            assign last_ok = (nls == MNLS) || (nls == ANLS);
        end else begin : g_no_alt
            assign last_ok = (nls == MNLS);
        end
    endgenerate

    always_comb begin
        legal = 1'b0;
        if (lvl == '0)
            legal = (size == RSIZE) && (nls == RNLS);
        else if (lvl < LAST_LVL)
            legal = (nls == MNLS);
        else if (lvl == LAST_LVL)
            legal = last_ok;
    end
endmodule

// File: rtl/radix_walk_leaf.sv
module radix_walk_leaf
    import radix_walk_pkg::*;
(
    input  logic [VA_W-1:0]  ea,
    input  logic [ENT_W-1:0] entry,
    input  logic [SZ_W-1:0]  size,
    output logic [VA_W-1:0]  real_addr
);
    logic [VA_W-1:0] off_mask;
    logic [VA_W-1:0] page;

    always_comb begin
        off_mask  = low_ones(MSK_W'(size));
        page      = entry & field_mask(RPN_HI, RPN_LO);
        real_addr = (page & ~off_mask) | (ea & off_mask);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int ROOT_SIZE = 52,
    parameter int ROOT_NLS  = 13,
    parameter int MID_NLS   = 9,
    parameter int ALT_NLS   = 5,
    parameter int DEPTH     = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [63:0] ea,
    input  logic [63:0] root_base,
    input  logic [4:0]  root_nls,
    input  logic [5:0]  root_size,
    output logic        busy,
    output logic        done,
    output logic [1:0]  cause,
    output logic [63:0] real_addr,
    output logic [5:0]  page_shift,
    output logic [63:0] leaf_entry,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_ack,
    input  logic [63:0] mem_rdata
);
    walk_state_e     st;
    walk_ctx_t       ctx;
    logic [VA_W-1:0] ea_q;
    logic [VA_W-1:0] addr_q;
    logic            done_q;
    walk_result_t    res_q;

    logic [VA_W-1:0] entry_addr;
    logic            lvl_legal;
    logic [SZ_W-1:0] next_size;
    logic [VA_W-1:0] leaf_raddr;

    radix_walk_index u_index (
        .ea         (ea_q),
        .base       (ctx.base),
        .size       (ctx.size),
        .nls        (ctx.nls),
        .entry_addr (entry_addr)
    );

    radix_walk_cfg #(
        .ROOT_SIZE (ROOT_SIZE),
        .ROOT_NLS  (ROOT_NLS),
        .MID_NLS   (MID_NLS),
        .ALT_NLS   (ALT_NLS),
        .DEPTH     (DEPTH)
    ) u_cfg (
        .lvl   (ctx.lvl),
        .size  (ctx.size),
        .nls   (ctx.nls),
        .legal (lvl_legal)
    );

    assign next_size = ctx.size - SZ_W'(ctx.nls);

    radix_walk_leaf u_leaf (
        .ea        (ea_q),
        .entry     (mem_rdata),
        .size      (next_size),
        .real_addr (leaf_raddr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ctx    <= '0;
            ea_q   <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
            res_q  <= '{cause: CAUSE_NONE, raddr: '0, shift: '0, leaf: '0};
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        ea_q     <= ea;
                        ctx.base <= root_base;
                        ctx.nls  <= root_nls;
                        ctx.size <= root_size;
                        ctx.lvl  <= '0;
                        st       <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!lvl_legal) begin
                        done_q <= 1'b1;
                        res_q  <= '{cause: CAUSE_BADCFG, raddr: '0, shift: '0, leaf: '0};
                        st     <= ST_IDLE;
                    end else begin
                        addr_q <= entry_addr;
                        st     <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (!mem_rdata[V_BIT]) begin
                            done_q <= 1'b1;
                            res_q  <= '{cause: CAUSE_NOENT, raddr: '0, shift: '0, leaf: '0};
                            st     <= ST_IDLE;
                        end else if (mem_rdata[L_BIT]) begin
                            done_q <= 1'b1;
                            res_q  <= '{cause: CAUSE_NONE, raddr: leaf_raddr,
                                        shift: next_size, leaf: mem_rdata};
                            st     <= ST_IDLE;
                        end else begin
                            ctx.base <= entry_next_base(mem_rdata);
                            ctx.nls  <= entry_next_nls(mem_rdata);
                            ctx.size <= next_size;
                            ctx.lvl  <= ctx.lvl + LVL_W'(1);
                            st       <= ST_CHECK;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (st != ST_IDLE);
    assign done       = done_q;
    assign cause      = res_q.cause;
    assign real_addr  = res_q.raddr;
    assign page_shift = res_q.shift;
    assign leaf_entry = res_q.leaf;
    assign mem_req    = (st == ST_READ);
    assign mem_addr   = addr_q;
endmodule

// File: rtl/radix_walk_chk.sv
module radix_walk_chk #(
    parameter int ROOT_SIZE = 52,
    parameter int ROOT_NLS  = 13,
    parameter int MID_NLS   = 9,
    parameter int ALT_NLS   = 5
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [1:0]  cause,
    input logic [5:0]  page_shift,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_ack
);
    localparam logic [5:0] S0  = 6'(ROOT_SIZE - ROOT_NLS);
    localparam logic [5:0] S1  = 6'(ROOT_SIZE - ROOT_NLS - MID_NLS);
    localparam logic [5:0] S2  = 6'(ROOT_SIZE - ROOT_NLS - 2 * MID_NLS);
    localparam logic [5:0] S3A = 6'(ROOT_SIZE - ROOT_NLS - 3 * MID_NLS);
    localparam logic [5:0] S3B = 6'(ROOT_SIZE - ROOT_NLS - 2 * MID_NLS - ALT_NLS);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R9

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy); // R11

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000)); // R2

    AST_SHIFT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (done && cause == 2'd0) |->
        (page_shift == S0 || page_shift == S1 || page_shift == S2 ||
         page_shift == S3A || page_shift == S3B)); // R7

    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && cause != 2'd0) |-> (page_shift == 6'd0)); // R9
endmodule

bind radix_walker radix_walk_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .cause      (cause),
    .page_shift (page_shift),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack)
);

// File: tb/radix_walker_bench.sv
`timescale 1ns/1ps
module radix_walker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] ea = '0, root_base = '0;
    logic [4:0]  root_nls = '0;
    logic [5:0]  root_size = '0;
    logic        busy, done, mem_req;
    logic [1:0]  cause;
    logic [63:0] real_addr, leaf_entry, mem_addr;
    logic [5:0]  page_shift;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;

    int n_chk = 0, n_bad = 0, reads = 0;
    logic [63:0] mem [logic [63:0]];

    always #4 clk = ~clk;

    radix_walker u_radix_walker (
        .clk(clk), .rst(rst), .start(start), .ea(ea), .root_base(root_base),
        .root_nls(root_nls), .root_size(root_size), .busy(busy), .done(done),
        .cause(cause), .real_addr(real_addr), .page_shift(page_shift),
        .leaf_entry(leaf_entry), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    localparam logic [63:0] NB_M  = 64'h00FF_FFFF_FFFF_FF00;
    localparam logic [63:0] RPN_M = 64'h00FF_FFFF_FFFF_F000;

    function automatic logic [63:0] lm(input int n);
        if (n >= 64) return '1;
        return (64'd1 << n) - 64'd1;
    endfunction

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic logic [63:0] eaddr(input logic [63:0] e, b, input int nls, size);
        return (b & ~lm(nls + 3)) + (((e >> (size - nls)) & lm(nls)) << 3);
    endfunction

    function automatic bit legal(input int lvl, size, nls);
        if (lvl == 0) return size == 52 && nls == 13;
        if (lvl == 1 || lvl == 2) return nls == 9;
        if (lvl == 3) return nls == 9 || nls == 5;
        return 1'b0;
    endfunction

    task automatic golden(input logic [63:0] e, b, input int nls, size,
                          output int gc, output logic [63:0] gra, output int gps,
                          output logic [63:0] gleaf, output int greads);
        logic [63:0] ent;
        gc = 0; gra = '0; gps = 0; gleaf = '0; greads = 0;
        for (int lvl = 0; lvl < 8; lvl++) begin
            if (!legal(lvl, size, nls)) begin gc = 2; return; end
            ent = rd(eaddr(e, b, nls, size));
            greads++;
            if (!ent[63]) begin gc = 1; return; end
            size = size - nls;
            if (ent[62]) begin
                gra = ((ent & RPN_M) & ~lm(size)) | (e & lm(size));
                gps = size; gleaf = ent; return;
            end
            b = ent & NB_M;
            nls = int'(ent[4:0]);
        end
        gc = 2;
    endtask

    // fkind: 0 leaf at leaf_lvl, 1 invalid at flvl, 2 bad nls at flvl, 3 run past level 3
    task automatic build(input logic [63:0] e, b, input int leaf_lvl, fkind, flvl);
        int nls = 13, size = 52, nxt;
        logic [63:0] a, nb;
        for (int lvl = 0; lvl < 4; lvl++) begin
            a = eaddr(e, b, nls, size);
            if (fkind == 1 && lvl == flvl) begin
                mem[a] = {1'b0, $urandom, $urandom} & ~(64'd1 << 63); return;
            end
            if (fkind != 3 && lvl == leaf_lvl) begin
                mem[a] = {2'b11, 30'($urandom), $urandom}; return;
            end
            if (fkind == 2 && lvl + 1 == flvl) nxt = 7;
            else if (lvl + 1 == 3) nxt = ($urandom % 2) ? 9 : 5;
            else nxt = 9;
            nb = {$urandom, $urandom} & NB_M;
            mem[a] = (64'd1 << 63) | nb | 64'(nxt);
            size = size - nls; b = nb; nls = nxt;
        end
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: ack after a random delay, one read at a time
    initial begin
        int dly = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && !rst) begin
                if (dly == 0) begin
                    mem_ack = 1'b1; mem_rdata = rd(mem_addr); reads++;
                    dly = int'($urandom % 3);
                end else dly--;
            end
        end
    end

    task automatic walk(input logic [63:0] e, b, input int nls, size,
                        input bit poke_busy, input string req);
        int gc, gps, greads, wait_n;
        logic [63:0] gra, gleaf;
        golden(e, b, nls, size, gc, gra, gps, gleaf, greads);
        @(negedge clk);
        reads = 0;
        ea = e; root_base = b; root_nls = 5'(nls); root_size = 6'(size); start = 1'b1;
        @(negedge clk);
        if (poke_busy) begin
            ea = ~e; root_base = b ^ 64'h10_0000; start = 1'b1;   // R10
            @(negedge clk);
        end
        start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 500) begin @(negedge clk); wait_n++; end
        chk(done, req, "done seen", 64'(done), 64'd1);
        chk(cause == 2'(gc), req, "cause", 64'(cause), 64'(gc));
        chk(real_addr == gra, req, "real_addr", real_addr, gra);
        chk(page_shift == 6'(gps), req, "page_shift", 64'(page_shift), 64'(gps));
        chk(leaf_entry == gleaf, (gc == 0) ? "R8" : "R9", "leaf_entry", leaf_entry, gleaf);
        chk(reads == greads, req, "read count", 64'(reads), 64'(greads));
        @(negedge clk);
        chk(!done, "R9", "done one cycle", 64'(done), 64'd0);
    endtask

    task automatic rand_walk(input int leaf_lvl, fkind, flvl, input string req);
        logic [63:0] e, b;
        mem.delete();
        e = {$urandom, $urandom};
        b = {$urandom, $urandom} & 64'h00FF_FFFF_FFFF_FFFF;   // low garbage exercises R3
        build(e, b, leaf_lvl, fkind, flvl);
        walk(e, b, 13, 52, 1'b0, req);
    endtask

    initial begin
        #1_200_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] e, b;
        int ll, fk;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "reset outputs",
            {61'd0, busy, done, mem_req}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "after reset",
            {61'd0, busy, done, mem_req}, 64'd0);

        // directed corners
        rand_walk(0, 0, 0, "R7");            // leaf at root: 39-bit page
        rand_walk(3, 0, 0, "R7");            // four-level walk
        rand_walk(2, 1, 0, "R5");            // invalid root entry
        rand_walk(3, 1, 3, "R5");            // invalid deepest entry
        rand_walk(2, 2, 1, "R4");            // bad nls at level 1
        rand_walk(3, 2, 3, "R4");            // bad nls at level 3
        rand_walk(0, 3, 0, "R4");            // beyond level 3
        mem.delete();
        walk(64'h1234, 64'h1000, 13, 48, 1'b0, "R4");   // bad root size, no read
        walk(64'h1234, 64'h1000, 12, 52, 1'b0, "R4");   // bad root nls, no read
        // level-3 index size 5 directed: build forces 5 where random picks it
        for (int i = 0; i < 6; i++) rand_walk(3, 0, 0, "R6");
        // start while busy
        mem.delete();
        e = {$urandom, $urandom}; b = {$urandom, $urandom} & 64'h00FF_FFFF_FFFF_FFFF;
        build(e, b, 3, 0, 0);
        walk(e, b, 13, 52, 1'b1, "R10");
        // misaligned root base explicitly
        mem.delete();
        e = {$urandom, $urandom}; b = 64'h0000_0012_3456_FFF8;
        build(e, b, 1, 0, 0);
        walk(e, b, 13, 52, 1'b0, "R3");

        // constrained random
        for (int i = 0; i < 300; i++) begin
            ll = int'($urandom % 4);
            fk = int'($urandom % 4);
            if (fk == 0) rand_walk(ll, 0, 0, "R2");
            else if (fk == 1) rand_walk(ll, 1, int'($urandom % (ll + 1)), "R5");
            else if (fk == 2 && ll > 0) rand_walk(ll, 2, 1 + int'($urandom % ll), "R4");
            else if (fk == 3 && ll == 3) rand_walk(0, 3, 0, "R4");
            else rand_walk(ll, 0, 0, "R7");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule